// File: doc/BRIEF.md
# Significand Rounding Unit

This block takes a significand that has already been normalized but not yet rounded, together with its sign and the three bits that a shifter leaves below it (guard, round and sticky). It returns the significand rounded under one of four rounding directions. A single increment decision is formed from the mode, the sign, the significand's lowest bit and the discarded bits. That decision then drives one adder.

When the increment ripples out of the top bit, the block raises a carry flag. It also presents the significand in renormalized form, with only its top bit set, so the surrounding datapath can add one to the exponent. An inexact flag reports whether any discarded bit was nonzero. The block can be built purely combinational, or with one output register stage selected by a parameter.

Top module: `rnd_unit`

## Requirements
- R1: The 2-bit mode input selects the rounding direction: 0 is nearest-even, 1 is toward zero, 2 is toward plus infinity and 3 is toward minus infinity.
- R2: In mode 0 the magnitude is incremented when guard is 1 and either round or sticky is 1. When guard is 1, round and sticky are both 0 and significand bit 0 is 1, the magnitude is also incremented, so an exact half always lands on an even result.
- R3: In mode 1 the significand output equals the significand input and the carry flag is 0, for every combination of sign and discarded bits.
- R4: In mode 2 the magnitude is incremented only when the sign is 0 (positive) and at least one of guard, round or sticky is 1. Negative values pass through truncated.
- R5: In mode 3 the magnitude is incremented only when the sign is 1 (negative) and at least one of guard, round or sticky is 1.
- R6: The inexact output is 1 exactly when at least one of guard, round or sticky is 1, in every mode.
- R7: Whenever no increment is taken, the significand output equals the input. Whenever an increment is taken without carry, the output equals the input plus one.
- R8: When the increment overflows an all-ones significand, the carry output is 1 and the significand output has only its most significant bit set.
- R9: With OUT_REG=1 the outputs change only at a rising clock edge and reflect the inputs sampled at that edge. While rst_n is low the outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| sig_in | input | SIG_W | Unrounded significand, bit 0 is the lowest kept bit |
| sign_in | input | 1 | Sign of the value, 1 is negative |
| guard_in | input | 1 | First discarded bit |
| round_in | input | 1 | Second discarded bit |
| sticky_in | input | 1 | OR of all further discarded bits |
| mode_in | input | 2 | Rounding direction selector |
| sig_out | output | SIG_W | Rounded significand |
| carry_out | output | 1 | Increment overflowed the significand |
| inexact_out | output | 1 | Some discarded bit was nonzero |

## Verification
The increment path and the carry renormalization can both act on the same vector. This happens when an all-ones significand meets a discarded fraction that the mode rounds up, such as an exact half in nearest-even (the all-ones value has an odd low bit), or any nonzero fraction on a positive value under rounding toward plus infinity. The sweep covers every significand of a 4-bit configuration against every sign, discarded-bit pattern and mode. It therefore provokes each of these collisions. The bench judges them by comparing against a result derived from the value counted in eighths of a unit, which predicts the wrap to the top-bit-only pattern and the raised inexact flag together.

// File: rtl/rnd_pkg.sv
// Package: shared encodings for the rounding unit.
// Assumes the mode input is exactly two bits wide.
package rnd_pkg;
    typedef enum logic [1:0] {
        RMODE_NEAREST = 2'd0,
        RMODE_ZERO    = 2'd1,
        RMODE_UP      = 2'd2,
        RMODE_DOWN    = 2'd3
    } rmode_e;
endpackage

// File: rtl/rnd_decide.sv
// Module: rnd_decide
// Forms the single increment decision and the inexact flag from the mode,
// the sign, the kept LSB and the guard/round/sticky bits.
// Assumes the discarded bits are already collapsed into three bits.
module rnd_decide
    import rnd_pkg::*;
(
    input  logic       lsb_in,
    input  logic       sign_in,
    input  logic       guard_in,
    input  logic       round_in,
    input  logic       sticky_in,
    input  logic [1:0] mode_in,
    output logic       incr_out,
    output logic       inexact_out
);
    logic any_lost;
    rmode_e mode;

    // Purpose: summarise the discarded bits and decode the mode.
    always_comb begin
        any_lost = guard_in | round_in | sticky_in;
        mode     = rmode_e'(mode_in);
    end

    // Purpose: choose whether the magnitude gains one unit.
    always_comb begin
        unique case (mode)
            RMODE_NEAREST: incr_out = guard_in & (round_in | sticky_in | lsb_in);
            RMODE_ZERO:    incr_out = 1'b0;
            RMODE_UP:      incr_out = ~sign_in & any_lost;
            RMODE_DOWN:    incr_out = sign_in & any_lost;
            default:       incr_out = 1'b0;
        endcase
    end

    assign inexact_out = any_lost;
endmodule

// File: rtl/rnd_incr.sv
// Module: rnd_incr
// Adds the increment decision to the significand. On overflow it raises a
// carry and returns the renormalized pattern (top bit only).
// Assumes SIG_W >= 2.
module rnd_incr #(
    parameter int SIG_W = 53
) (
    input  logic [SIG_W-1:0] sig_in,
    input  logic             incr_in,
    output logic [SIG_W-1:0] sig_out,
    output logic             carry_out
);
    localparam int SUM_W = SIG_W + 1;
    localparam logic [SIG_W-1:0] TOP_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

    logic [SUM_W-1:0] sum;

    // Purpose: one wide adder plus renormalization on wrap.
    always_comb begin
        sum       = {1'b0, sig_in} + {{SIG_W{1'b0}}, incr_in};
        carry_out = sum[SUM_W-1];
        sig_out   = carry_out ? TOP_ONLY : sum[SIG_W-1:0];
    end
endmodule

// File: rtl/rnd_outstage.sv
// Module: rnd_outstage
// Passes the rounded result through, or registers it when OUT_REG=1.
// Assumes synchronous active-low reset clearing every output to zero.
module rnd_outstage #(
    parameter int SIG_W   = 53,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] sig_d,
    input  logic             carry_d,
    input  logic             inexact_d,
    output logic [SIG_W-1:0] sig_q,
    output logic             carry_q,
    output logic             inexact_q
);
    generate
        if (OUT_REG) begin : g_reg
            // Purpose: hold the result for one cycle of latency.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sig_q     <= '0;
                    carry_q   <= 1'b0;
                    inexact_q <= 1'b0;
                end else begin
                    sig_q     <= sig_d;
                    carry_q   <= carry_d;
                    inexact_q <= inexact_d;
                end
            end
        end else begin : g_pass
            // Purpose: zero-latency path.
            always_comb begin
                sig_q     = sig_d;
                carry_q   = carry_d;
                inexact_q = inexact_d;
            end
        end
    endgenerate
endmodule

// File: rtl/rnd_unit.sv
// Module: rnd_unit (top)
// Rounds a normalized significand under four IEEE rounding directions.
// It reports a carry for exponent adjustment and an inexact flag.
// Assumes normalization and exponent handling are done by the caller.
module rnd_unit #(
    parameter int SIG_W   = 53,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIG_W-1:0] sig_in,
    input  logic             sign_in,
    input  logic             guard_in,
    input  logic             round_in,
    input  logic             sticky_in,
    input  logic [1:0]       mode_in,
    output logic [SIG_W-1:0] sig_out,
    output logic             carry_out,
    output logic             inexact_out
);
    logic             incr;
    logic             inexact_c;
    logic [SIG_W-1:0] sig_c;
    logic             carry_c;

    rnd_decide u_decide (
        .lsb_in      (sig_in[0]),
        .sign_in     (sign_in),
        .guard_in    (guard_in),
        .round_in    (round_in),
        .sticky_in   (sticky_in),
        .mode_in     (mode_in),
        .incr_out    (incr),
        .inexact_out (inexact_c)
    );

    rnd_incr #(.SIG_W(SIG_W)) u_incr (
        .sig_in    (sig_in),
        .incr_in   (incr),
        .sig_out   (sig_c),
        .carry_out (carry_c)
    );

    rnd_outstage #(.SIG_W(SIG_W), .OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_d     (sig_c),
        .carry_d   (carry_c),
        .inexact_d (inexact_c),
        .sig_q     (sig_out),
        .carry_q   (carry_out),
        .inexact_q (inexact_out)
    );
endmodule

// File: rtl/rnd_unit_chk.sv
// Module: rnd_unit_chk
// Checker bound to rnd_unit. It keeps its own copy of the inputs, delayed to
// match OUT_REG, and relates them to the outputs.
module rnd_unit_chk #(
    parameter int SIG_W   = 53,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SIG_W-1:0] sig_in,
    input logic             sign_in,
    input logic             guard_in,
    input logic             round_in,
    input logic             sticky_in,
    input logic [1:0]       mode_in,
    input logic [SIG_W-1:0] sig_out,
    input logic             carry_out,
    input logic             inexact_out
);
    localparam logic [SIG_W-1:0] TOP_ONLY = {1'b1, {(SIG_W-1){1'b0}}};

    logic [SIG_W-1:0] q_sig;
    logic             q_sign, q_lost, q_ok;
    logic [1:0]       q_mode;
    logic [SIG_W-1:0] r_sig;
    logic             r_sign, r_lost, r_ok;
    logic [1:0]       r_mode;

    // Purpose: capture inputs one edge earlier for the registered variant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_sig  <= '0;
            q_sign <= 1'b0;
            q_lost <= 1'b0;
            q_mode <= 2'd0;
            q_ok   <= 1'b0;
        end else begin
            q_sig  <= sig_in;
            q_sign <= sign_in;
            q_lost <= guard_in | round_in | sticky_in;
            q_mode <= mode_in;
            q_ok   <= 1'b1;
        end
    end

    generate
        if (OUT_REG) begin : g_lat
            always_comb begin
                r_sig = q_sig; r_sign = q_sign; r_lost = q_lost;
                r_mode = q_mode; r_ok = q_ok;
            end
        end else begin : g_now
            always_comb begin
                r_sig = sig_in; r_sign = sign_in;
                r_lost = guard_in | round_in | sticky_in;
                r_mode = mode_in; r_ok = 1'b1;
            end
        end
    endgenerate

    assert_inexact_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_ok |-> (inexact_out == r_lost));
    assert_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ok && r_mode == 2'd1) |-> (sig_out == r_sig && !carry_out));
    assert_neg_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ok && r_mode == 2'd2 && r_sign) |-> (sig_out == r_sig && !carry_out));
    assert_pos_trunc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ok && r_mode == 2'd3 && !r_sign) |-> (sig_out == r_sig && !carry_out));
    assert_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ok && !r_lost) |-> (sig_out == r_sig && !carry_out));
    assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ok && !carry_out) |-> (sig_out == r_sig || sig_out == r_sig + 1'b1));
    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ok && carry_out) |-> (sig_out == TOP_ONLY && &r_sig));
endmodule

bind rnd_unit rnd_unit_chk #(.SIG_W(SIG_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/rnd_unit_test.sv
// Bench: exhaustive sweep of a 4-bit registered configuration.
module rnd_unit_test;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] sig_in = '0;
    logic sign_in = 1'b0, guard_in = 1'b0, round_in = 1'b0, sticky_in = 1'b0;
    logic [1:0] mode_in = 2'd0;
    logic [W-1:0] sig_out;
    logic carry_out, inexact_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rnd_unit #(.SIG_W(W), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .sign_in(sign_in),
        .guard_in(guard_in), .round_in(round_in), .sticky_in(sticky_in),
        .mode_in(mode_in), .sig_out(sig_out), .carry_out(carry_out),
        .inexact_out(inexact_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int last_sig;
        // Reset state (R9)
        sig_in = 4'hF; guard_in = 1'b1; mode_in = 2'd2;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset sig", sig_out, 0);
        check("R9 reset carry", carry_out, 0);
        check("R9 reset inexact", inexact_out, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int v = 0; v < 16; v++) begin
                    for (int grs = 0; grs < 8; grs++) begin
                        int up, nv, exp_sig, exp_c;
                        string tag;
                        @(negedge clk);
                        sig_in = v[W-1:0]; sign_in = s[0]; mode_in = m[1:0];
                        guard_in = grs[2]; round_in = grs[1]; sticky_in = grs[0];
                        // remainder in eighths of a unit is grs itself
                        case (m)
                            0: begin up = (grs > 4 || (grs == 4 && v % 2 == 1)) ? 1 : 0;
                                     tag = (grs == 4) ? "R2 tie" : "R2 R1 nearest"; end
                            1: begin up = 0; tag = "R3 R1 zero"; end
                            2: begin up = (grs != 0 && s == 0) ? 1 : 0; tag = "R4 R1 up"; end
                            default: begin up = (grs != 0 && s == 1) ? 1 : 0; tag = "R5 R1 down"; end
                        endcase
                        nv = v + up;
                        exp_c = (nv == 16) ? 1 : 0;
                        exp_sig = exp_c ? 8 : nv;
                        if (exp_c == 1) tag = {tag, " R8 wrap"};
                        else if (up == 0) tag = {tag, " R7 hold"};
                        @(posedge clk); #1;
                        check(tag, sig_out, exp_sig);
                        check({tag, " carry"}, carry_out, exp_c);
                        check("R6 inexact", inexact_out, (grs != 0) ? 1 : 0);
                    end
                end
            end
        end

        // Registered output holds between edges (R9)
        last_sig = sig_out;
        @(negedge clk);
        sig_in = 4'h3; guard_in = 1'b1; round_in = 1'b1; sticky_in = 1'b0;
        sign_in = 1'b0; mode_in = 2'd0;
        #1;
        check("R9 hold before edge", sig_out, last_sig);
        @(posedge clk); #1;
        check("R9 update at edge", sig_out, 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule